// File: doc/BRIEF.md
# Bandwidth-Quota Round-Robin Arbiter

This block shares one resource among a set of equal-priority masters, one time unit (one clock cycle, one data unit) per grant. Each master carries a programmable weight: the number of time units it may be granted inside a window whose length is also programmable. Arbitration runs in two stages. First a quota filter masks out any master whose allowance for the current window is spent. Then a rotating-pointer round-robin stage picks one of the remaining requesters. Over a window in which every master keeps requesting, each master's share of time units therefore follows the ratio of the weights.

A free-running window counter marks the first cycle of each window. In that cycle every quota is refilled from its weight, and the refilled value is the one used for that cycle's decision. Each grant takes one unit off the granted master's quota. The grant, the per-master remaining quota and the per-master exhausted flag are all registered, so a decision made at one clock edge appears on the outputs just after that edge.

Top module: `bwq_rr_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `grant` is all zero. Each master's `quota_left` field equals its weight, and `exhausted[i]` is 1 exactly when weight i is zero.
- R2: `grant` is one-hot or zero. A bit is set only for a master whose `req` bit was high when the decision was made, which is the edge before the grant appears.
- R3: Each grant lowers the granted master's `quota_left` by exactly one at the same edge. When that edge is also a window start, the refilled value is used instead of the old one. Master i's quota is field `quota_left[i*WEIGHT_W +: WEIGHT_W]`, and weight i sits in the same position of `weight`.
- R4: A master whose quota is zero is not granted again until the next window start. `exhausted[i]` is 1 exactly when master i's `quota_left` is zero.
- R5: Windows start on the first edge after reset and then every `window_len` edges. At a window start every quota is refilled from the current weight. A `window_len` of 0 or 1 makes every edge a window start.
- R6: The search for a grant starts at a rotating pointer and goes upward through the indices, wrapping from the highest to 0. The pointer is 0 after reset. After each grant the pointer moves to the index just after the granted master.
- R7: With weights 4, 2, 1, 0, all four masters requesting and a window of 7, each window grants exactly 4, 2, 1 and 0 time units. In the first window the order is 0, 1, 2, 0, 1, 0, 0.
- R8: If any requesting master has quota left, a grant is issued. If every requesting master is exhausted, `grant` stays zero until the next window start.
- R9: A master with weight zero is never granted.
- R10: A weight change made in the middle of a window takes effect only at the next window start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_MASTERS | Request bit per master |
| weight | input | NUM_MASTERS*WEIGHT_W | Time units allowed per window, one field per master |
| window_len | input | WIN_W | Window length in cycles |
| grant | output | NUM_MASTERS | Registered one-hot grant |
| quota_left | output | NUM_MASTERS*WEIGHT_W | Remaining quota, one field per master |
| exhausted | output | NUM_MASTERS | Quota-spent flag per master |

## Verification
On every cycle the assertions check the following:
- the grant is one-hot and follows a request;
- an exhausted master is never granted;
- the quota drops by one per grant and is refilled at each window start;
- the window counter stays in bounds and wraps;
- the pointer sits just after the last grant;
- a grant is issued whenever a master is eligible.

Only the directed scenarios show the end-to-end effects: the exact per-window counts for a weight ratio, the order in which masters are served, the idle gap after every quota is spent, the delayed effect of a weight change, and the one-cycle window case.

// File: rtl/bwq_pkg.sv
package bwq_pkg;

  // Index arithmetic modulo a count, used by the rotating search.
  function automatic int unsigned mod_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned n);
    int unsigned s;
    s = a + b;
    while (s >= n) s = s - n;
    return s;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bwq_window_timer.sv
module bwq_window_timer #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_start
);

  logic [WIN_W-1:0] cnt;
  logic [WIN_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_inc >= {1'b0, win_len}) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_inc[WIN_W-1:0];
    end
  end

  assign win_start = (cnt == '0);

  // R5: counter stays inside a stable window length
  p_win_bound_r5: assert property (@(posedge clk) disable iff (rst)
    ($stable(win_len) && win_len != '0) |-> (cnt < win_len));

  // R5: the last cycle of a window is followed by a window start
  p_win_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ($stable(win_len) && win_len > 1 && {1'b0, cnt} == {1'b0, win_len} - 1'b1)
      |=> win_start);

endmodule

// File: rtl/bwq_quota_slot.sv
module bwq_quota_slot #(
  parameter int WEIGHT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                refill,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic                take,
  output logic                avail,
  output logic [WEIGHT_W-1:0] quota,
  output logic                empty
);

  logic [WEIGHT_W-1:0] eff_quota;
  logic [WEIGHT_W-1:0] next_quota;

  // At a window start the fresh weight is the quota used for this decision.
  assign eff_quota  = refill ? weight : quota;
  assign avail      = (eff_quota != '0);
  assign next_quota = (take && avail) ? eff_quota - 1'b1 : eff_quota;

  always_ff @(posedge clk) begin
    if (rst) begin
      quota <= weight;
      empty <= (weight == '0);
    end else begin
      quota <= next_quota;
      empty <= (next_quota == '0);
    end
  end

  // R4: the arbiter only takes from a slot with quota left
  p_take_avail_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> avail);

  // R3: a grant outside a window start costs exactly one unit
  p_quota_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (!refill && take) |=> (quota == $past(quota) - 1'b1));

  // R5: a window start without a grant restores the weight
  p_refill_r5: assert property (@(posedge clk) disable iff (rst)
    (refill && !take) |=> (quota == $past(weight)));

  // R10: away from window starts and grants the quota holds
  p_quota_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!refill && !take) |=> $stable(quota));

endmodule

// File: rtl/bwq_rr_core.sv
module bwq_rr_core
  import bwq_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_MASTERS-1:0] elig,
  output logic [NUM_MASTERS-1:0] pick,
  output logic [NUM_MASTERS-1:0] grant
);

  localparam int PTR_W = idx_width(NUM_MASTERS);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] sel;
  logic [PTR_W-1:0] ptr_next;
  logic [PTR_W-1:0] prev_idx;
  logic             found;

  // Search upward from the pointer, wrapping at the top.
  always_comb begin
    pick  = '0;
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      int unsigned j;
      j = mod_add(int'(ptr), k, NUM_MASTERS);
      if (!found && elig[j]) begin
        pick[j] = 1'b1;
        sel     = PTR_W'(j);
        found   = 1'b1;
      end
    end
  end

  assign ptr_next = PTR_W'(mod_add(int'(sel), 1, NUM_MASTERS));
  assign prev_idx = (ptr == '0) ? PTR_W'(NUM_MASTERS - 1) : ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      grant <= '0;
    end else begin
      grant <= pick;
      if (found) ptr <= ptr_next;
    end
  end

  // R2: at most one master granted
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6: after a grant the pointer sits just above the granted master
  p_ptr_after_r6: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> grant[prev_idx]);

  // R8: any eligible master leads to a grant
  p_work_conserving_r8: assert property (@(posedge clk) disable iff (rst)
    (|elig) |=> (|grant));

  // R8: nothing eligible means no grant
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(|elig) |=> (grant == '0));

endmodule

// File: rtl/bwq_rr_arbiter.sv
module bwq_rr_arbiter #(
  parameter int NUM_MASTERS = 4,
  parameter int WEIGHT_W    = 8,
  parameter int WIN_W       = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_MASTERS-1:0]          req,
  input  logic [NUM_MASTERS*WEIGHT_W-1:0] weight,
  input  logic [WIN_W-1:0]                window_len,
  output logic [NUM_MASTERS-1:0]          grant,
  output logic [NUM_MASTERS*WEIGHT_W-1:0] quota_left,
  output logic [NUM_MASTERS-1:0]          exhausted
);

  logic                   win_start;
  logic [NUM_MASTERS-1:0] avail;
  logic [NUM_MASTERS-1:0] elig;
  logic [NUM_MASTERS-1:0] pick;

  bwq_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .win_len  (window_len),
    .win_start(win_start)
  );

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_slot
    bwq_quota_slot #(.WEIGHT_W(WEIGHT_W)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .refill(win_start),
      .weight(weight[i*WEIGHT_W +: WEIGHT_W]),
      .take  (pick[i]),
      .avail (avail[i]),
      .quota (quota_left[i*WEIGHT_W +: WEIGHT_W]),
      .empty (exhausted[i])
    );

    // R4: an exhausted master stays ungranted until a window start
    p_no_grant_exhausted_r4: assert property (@(posedge clk) disable iff (rst)
      (exhausted[i] && !win_start) |=> !grant[i]);

    // R9: a zero weight is never granted
    p_zero_weight_r9: assert property (@(posedge clk) disable iff (rst)
      (weight[i*WEIGHT_W +: WEIGHT_W] == '0 && win_start) |=> !grant[i]);
  end

  // Bandwidth filter first, round-robin second.
  assign elig = req & avail;

  bwq_rr_core #(.NUM_MASTERS(NUM_MASTERS)) u_rr (
    .clk  (clk),
    .rst  (rst),
    .elig (elig),
    .pick (pick),
    .grant(grant)
  );

  // R2: a grant always answers a request seen at the deciding edge
  p_grant_req_r2: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (|(grant & $past(req))));

endmodule

// File: tb/bwq_rr_arbiter_test.sv
`timescale 1ns/1ps
module bwq_rr_arbiter_test;

  localparam int N  = 4;
  localparam int WW = 8;
  localparam int LW = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    req;
  logic [N*WW-1:0] weight;
  logic [LW-1:0]   window_len;
  logic [N-1:0]    grant;
  logic [N*WW-1:0] quota_left;
  logic [N-1:0]    exhausted;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  bwq_rr_arbiter #(.NUM_MASTERS(N), .WEIGHT_W(WW), .WIN_W(LW)) uut (
    .clk(clk), .rst(rst), .req(req), .weight(weight),
    .window_len(window_len), .grant(grant),
    .quota_left(quota_left), .exhausted(exhausted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [N*WW-1:0] pack_w(input int w0, input int w1,
                                             input int w2, input int w3);
    return {WW'(w3), WW'(w2), WW'(w1), WW'(w0)};
  endfunction

  function automatic int qf(input int i);
    return int'(quota_left[i*WW +: WW]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input logic [N*WW-1:0] w, input int wl, input logic [N-1:0] r);
    @(negedge clk);
    rst = 1'b1; weight = w; window_len = LW'(wl); req = r;
    repeat (3) step();
    rst = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    start(pack_w(3, 0, 5, 1), 8, 4'b1111);
    rst = 1'b1; step();
    chk(grant == '0, "R1 grant in reset", int'(grant), 0);
    chk(qf(0) == 3 && qf(2) == 5, "R1 quota loaded", qf(2), 5);
    chk(exhausted == 4'b0010, "R1 exhausted only zero weight", int'(exhausted), 2);
    rst = 1'b0;
  endtask

  // R7, R6, R9, R2: weighted ratio and service order
  task automatic t_ratio();
    int order[7] = '{0, 1, 2, 0, 1, 0, 0};
    int exp_cnt[N] = '{4, 2, 1, 0};
    start(pack_w(4, 2, 1, 0), 7, 4'b1111);
    for (int w = 0; w < 2; w++) begin
      int cnt[N] = '{0, 0, 0, 0};
      for (int c = 0; c < 7; c++) begin
        step();
        chk($onehot0(grant), "R2 onehot", int'(grant), 1);
        if (w == 0)
          chk(grant == (4'b1 << order[c]), "R6 order", int'(grant), 1 << order[c]);
        for (int i = 0; i < N; i++) if (grant[i]) cnt[i]++;
      end
      for (int i = 0; i < N; i++)
        chk(cnt[i] == exp_cnt[i], "R7 window count", cnt[i], exp_cnt[i]);
      chk(cnt[3] == 0, "R9 zero weight", cnt[3], 0);
    end
  endtask

  // R3, R4: decrement and exhausted flag
  task automatic t_decrement();
    start(pack_w(3, 3, 3, 3), 20, 4'b0010);
    for (int k = 2; k >= 0; k--) begin
      step();
      chk(grant == 4'b0010, "R3 granted", int'(grant), 2);
      chk(qf(1) == k, "R3 quota decrement", qf(1), k);
      chk(qf(0) == 3, "R3 others untouched", qf(0), 3);
    end
    chk(exhausted == 4'b0010, "R4 exhausted flag", int'(exhausted), 2);
    step();
    chk(grant == '0, "R4 no grant when spent", int'(grant), 0);
  endtask

  // R8, R5, R4: all spent, idle, then window restart
  task automatic t_exhaust();
    start(pack_w(1, 1, 1, 1), 10, 4'b1111);
    for (int c = 0; c < 4; c++) begin
      step();
      chk(grant == (4'b1 << c), "R8 serve each", int'(grant), 1 << c);
    end
    chk(exhausted == 4'b1111, "R4 all exhausted", int'(exhausted), 15);
    for (int c = 0; c < 6; c++) begin
      step();
      chk(grant == '0, "R8 idle when all spent", int'(grant), 0);
    end
    step();
    chk(grant == 4'b0001, "R5 reload at window start", int'(grant), 1);
    chk(exhausted == 4'b0001, "R5 flags refilled", int'(exhausted), 1);
  endtask

  // R2, R6: subset of requesters alternates
  task automatic t_subset();
    start(pack_w(4, 4, 4, 4), 16, 4'b1010);
    for (int c = 0; c < 6; c++) begin
      logic [N-1:0] e;
      e = (c % 2 == 0) ? 4'b0010 : 4'b1000;
      step();
      chk(grant == e, "R2/R6 subset rotation", int'(grant), int'(e));
    end
  endtask

  // R10: mid-window weight change waits for next window
  task automatic t_weight_change();
    int cnt;
    start(pack_w(2, 2, 2, 2), 8, 4'b0001);
    cnt = 0;
    for (int c = 0; c < 8; c++) begin
      step();
      if (c == 1) weight = pack_w(5, 2, 2, 2);
      if (grant[0]) cnt++;
    end
    chk(cnt == 2, "R10 old weight this window", cnt, 2);
    cnt = 0;
    for (int c = 0; c < 8; c++) begin
      step();
      if (grant[0]) cnt++;
    end
    chk(cnt == 5, "R10 new weight next window", cnt, 5);
  endtask

  // R5: one-cycle window refills every edge
  task automatic t_short_window();
    int cnt;
    start(pack_w(1, 1, 1, 1), 1, 4'b0001);
    cnt = 0;
    for (int c = 0; c < 5; c++) begin
      step();
      if (grant == 4'b0001) cnt++;
    end
    chk(cnt == 5, "R5 window of one", cnt, 5);
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req = '0; weight = '0; window_len = LW'(4);
    t_reset();
    t_ratio();
    t_decrement();
    t_exhaust();
    t_subset();
    t_weight_change();
    t_short_window();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule